// File: doc/BRIEF.md
# Privileged Status, Interrupt and Trap Register File

This block holds the machine-level and supervisor-level control registers of a processor hart: the status word, the interrupt pending, enable and delegation words, the trap vector, exception PC, scratch, cause and bad-address registers, the translation base, and the two counter-enable words. One port serves all of them. The port carries a 12-bit register address, write data and a write enable, and returns read data and an illegal-access flag. Reads are combinational. A write takes effect on the rising clock edge and changes exactly one register.

Every write passes through a per-register mask. The status word also has field legalization: an illegal translation-mode or previous-privilege value leaves the old field in place. A summary dirty bit is recomputed after every status update. The supervisor status, pending and enable registers have no storage of their own. They are filtered windows onto the machine registers. Reads of the user and supervisor counter aliases return the externally supplied counters only when the matching enable bit is set. A change to any field that affects translation raises a flush request in the same cycle as the write.

Parameters select the register width (32 or 64), whether a custom extension is present, the hart ID, the ISA word and the trap vector reset value.

Top module: `priv_csr_file`

## Requirements
- R1: After reset every register reads zero, except the machine trap vector (address 0x305), which reads the RESET_MTVEC parameter.
- R2: A write to the machine status register (0x300) changes only bits 1, 3, 5, 7, 8, 13-14, 17 and 18, and changes bits 15-16 only when HAS_EXT is set. The translation-mode field (bits 24-28) and the previous-privilege field (bits 11-12) follow R3 and R4.
- R3: The translation-mode field takes the written value only if that value is legal: 0 at either width, 8 at width 32, and 9 or 10 at width 64. Any other value leaves the field unchanged.
- R4: The previous-privilege field takes the written value only if it is 0, 1 or 3. The value 2 leaves the field unchanged.
- R5: After each status update, bit XLEN-1 of the status word is 1 exactly when bits 13-14 are 2'b11 or bits 15-16 are 2'b11.
- R6: flush_o is high during a write cycle to 0x300 or 0x100 whose requested value differs from the stored word in bits 24-28, 11-12, 17 or 18. Otherwise it is low.
- R7: Interrupt bit positions are: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7, supervisor external 9, coprocessor 12. A write to pending (0x344) changes only bits 1 and 5. A write to enable (0x304) changes only bits 1, 3, 5, 7, 9 and 12. A write to delegation (0x303) changes only bits 1, 5, 9 and 12.
- R8: The supervisor status register (0x100) reads and writes only bits 1, 5, 8, 13-16 and 18 of the machine status word. Its top bit is recomputed on read as in R5.
- R9: The supervisor pending register (0x144) and the supervisor enable register (0x104) read and write only those bits of the machine pending and enable registers that are set in the delegation register. Writes are further limited by the masks of R7.
- R10: Writes to the trap vectors (0x305, 0x105) clear bits 1:0. The user counter enable (0x320) and supervisor counter enable (0x321) keep only bits 2:0.
- R11: The user aliases 0xC00/0xC01/0xC02 (cycle, time, instret) are gated by user-enable bits 0/1/2, and the supervisor aliases 0xD00-0xD02 by supervisor-enable bits 0/1/2. A gated alias returns the low XLEN bits of its counter input. A disabled alias, and any address that is not decoded, raises illegal_o.
- R12: The high-half counter aliases (0xC80-0xC82, 0xD80-0xD82, and machine 0xB80/0xB82) are legal only at width 32 and return bits 63:32. The machine counters are at 0xB00 (cycle) and 0xB02 (instret).
- R13: The vendor, architecture and implementation IDs (0xF11-0xF13) read zero, the hart ID (0xF14) reads HART_ID, and the ISA word (0x301) reads ISA_BITS. Writes to them have no effect.
- R14: A write changes only the addressed register, and a write to an undecoded address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register address |
| wdata_i | input | XLEN | Write data |
| we_i | input | 1 | Write enable |
| mcycle_i | input | 64 | Cycle counter value |
| mtime_i | input | 64 | Time counter value |
| minstret_i | input | 64 | Retired-instruction counter value |
| rdata_o | output | XLEN | Read data for addr_i |
| illegal_o | output | 1 | Address not decoded or counter alias disabled |
| flush_o | output | 1 | Translation flush request during a status write |

## Verification
The assertions check, on every cycle, the invariants of the stored state. The status word never holds an illegal mode or privilege value. Its summary bit always matches the dirty fields. Interrupt words never contain bits outside their masks. The trap vectors always read aligned. Nothing changes in a cycle without a write, and a flush request only appears during a status write. Only the directed scenarios can show which value a particular write produces: a rejected mode or privilege value keeps the old field, the supervisor windows track the delegation word, counter aliases are gated per enable bit, and the width-dependent cases behave differently on the 32-bit and 64-bit instances.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef logic [11:0] csr_addr_t;

  localparam csr_addr_t A_SSTATUS   = 12'h100;
  localparam csr_addr_t A_SIE       = 12'h104;
  localparam csr_addr_t A_STVEC     = 12'h105;
  localparam csr_addr_t A_SSCRATCH  = 12'h140;
  localparam csr_addr_t A_SEPC      = 12'h141;
  localparam csr_addr_t A_SCAUSE    = 12'h142;
  localparam csr_addr_t A_SBADADDR  = 12'h143;
  localparam csr_addr_t A_SIP       = 12'h144;
  localparam csr_addr_t A_SPTBR     = 12'h180;
  localparam csr_addr_t A_MSTATUS   = 12'h300;
  localparam csr_addr_t A_MISA      = 12'h301;
  localparam csr_addr_t A_MEDELEG   = 12'h302;
  localparam csr_addr_t A_MIDELEG   = 12'h303;
  localparam csr_addr_t A_MIE       = 12'h304;
  localparam csr_addr_t A_MTVEC     = 12'h305;
  localparam csr_addr_t A_UCNTEN    = 12'h320;
  localparam csr_addr_t A_SCNTEN    = 12'h321;
  localparam csr_addr_t A_MSCRATCH  = 12'h340;
  localparam csr_addr_t A_MEPC      = 12'h341;
  localparam csr_addr_t A_MCAUSE    = 12'h342;
  localparam csr_addr_t A_MBADADDR  = 12'h343;
  localparam csr_addr_t A_MIP       = 12'h344;
  localparam csr_addr_t A_MCYCLE    = 12'hB00;
  localparam csr_addr_t A_MINSTRET  = 12'hB02;
  localparam csr_addr_t A_MCYCLEH   = 12'hB80;
  localparam csr_addr_t A_MINSTRETH = 12'hB82;
  localparam csr_addr_t A_UCNT      = 12'hC00;
  localparam csr_addr_t A_UCNTH     = 12'hC80;
  localparam csr_addr_t A_SCNT      = 12'hD00;
  localparam csr_addr_t A_SCNTH     = 12'hD80;
  localparam csr_addr_t A_VENDOR    = 12'hF11;
  localparam csr_addr_t A_ARCH      = 12'hF12;
  localparam csr_addr_t A_IMPL      = 12'hF13;
  localparam csr_addr_t A_HART      = 12'hF14;

  localparam int NUM_CNT   = 3;
  localparam int ST_MPP_LO = 11;
  localparam int ST_FS_LO  = 13;
  localparam int ST_XS_LO  = 15;
  localparam int ST_VM_LO  = 24;
  localparam int VM_W      = 5;

  localparam logic [VM_W-1:0] VM_BARE = 5'd0;
  localparam logic [VM_W-1:0] VM_SV32 = 5'd8;
  localparam logic [VM_W-1:0] VM_SV39 = 5'd9;
  localparam logic [VM_W-1:0] VM_SV48 = 5'd10;
  localparam logic [1:0]      PRV_RSV = 2'b10;

  localparam logic [63:0] ST_BASE_WMASK = 64'h0000_0000_0006_61AA;
  localparam logic [63:0] ST_XS_MASK    = 64'h0000_0000_0001_8000;
  localparam logic [63:0] ST_MPP_MASK   = 64'h0000_0000_0000_1800;
  localparam logic [63:0] ST_VM_MASK    = 64'h0000_0000_1F00_0000;
  localparam logic [63:0] ST_SVIEW_MASK = 64'h0000_0000_0005_E122;
  localparam logic [63:0] ST_FLUSH_MASK = 64'h0000_0000_1F06_1800;

  localparam logic [63:0] IP_SW_MASK    = 64'h0000_0000_0000_0022;
  localparam logic [63:0] IRQ_DELEG_MASK = 64'h0000_0000_0000_1222;
  localparam logic [63:0] IRQ_ALL_MASK  = 64'h0000_0000_0000_12AA;
endpackage

// File: rtl/csr_status_unit.sv
module csr_status_unit
  import csr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_EXT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_m_i,
  input  logic            wr_s_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] status_o,
  output logic            flush_o
);
  localparam logic [XLEN-1:0] WMASK  = XLEN'(ST_BASE_WMASK | (HAS_EXT ? ST_XS_MASK : 64'h0));
  localparam logic [XLEN-1:0] SMASK  = XLEN'(ST_SVIEW_MASK);
  localparam logic [XLEN-1:0] VMMASK = XLEN'(ST_VM_MASK);
  localparam logic [XLEN-1:0] PMASK  = XLEN'(ST_MPP_MASK);
  localparam logic [XLEN-1:0] FMASK  = XLEN'(ST_FLUSH_MASK);

  logic [XLEN-1:0] q, cand, mask, nxt;
  logic [VM_W-1:0] vm;
  logic            vm_ok, mpp_ok, wr;

  assign wr = wr_m_i | wr_s_i;

  always_comb begin
    // supervisor view keeps everything outside its window
    cand   = wr_s_i ? ((q & ~SMASK) | (wdata_i & SMASK)) : wdata_i;
    vm     = cand[ST_VM_LO +: VM_W];
    vm_ok  = (vm == VM_BARE) ||
             ((XLEN == 32) && (vm == VM_SV32)) ||
             ((XLEN == 64) && ((vm == VM_SV39) || (vm == VM_SV48)));
    mpp_ok = cand[ST_MPP_LO +: 2] != PRV_RSV;
    mask   = WMASK | (vm_ok ? VMMASK : '0) | (mpp_ok ? PMASK : '0);
    nxt    = (q & ~mask) | (cand & mask);
    nxt[XLEN-1] = (nxt[ST_FS_LO +: 2] == 2'b11) || (nxt[ST_XS_LO +: 2] == 2'b11);
  end

  assign flush_o = wr && (((cand ^ q) & FMASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (wr)  q <= nxt;
  end

  assign status_o = q;
endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
  import csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_mip_i,
  input  logic            wr_sip_i,
  input  logic            wr_mie_i,
  input  logic            wr_sie_i,
  input  logic            wr_deleg_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mip_o,
  output logic [XLEN-1:0] mie_o,
  output logic [XLEN-1:0] mideleg_o
);
  localparam logic [XLEN-1:0] PMASK = XLEN'(IP_SW_MASK);
  localparam logic [XLEN-1:0] EMASK = XLEN'(IRQ_ALL_MASK);
  localparam logic [XLEN-1:0] DMASK = XLEN'(IRQ_DELEG_MASK);

  logic [XLEN-1:0] mip_q, mie_q, deleg_q, ip_src, ie_src;

  always_comb begin
    ip_src = wr_sip_i ? ((mip_q & ~deleg_q) | (wdata_i & deleg_q)) : wdata_i;
    ie_src = wr_sie_i ? ((mie_q & ~deleg_q) | (wdata_i & deleg_q)) : wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mip_q   <= '0;
      mie_q   <= '0;
      deleg_q <= '0;
    end else begin
      if (wr_mip_i || wr_sip_i) mip_q <= (mip_q & ~PMASK) | (ip_src & PMASK);
      if (wr_mie_i || wr_sie_i) mie_q <= (mie_q & ~EMASK) | (ie_src & EMASK);
      if (wr_deleg_i)           deleg_q <= wdata_i & DMASK;
    end
  end

  assign mip_o     = mip_q;
  assign mie_o     = mie_q;
  assign mideleg_o = deleg_q;
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          HART_ID  = 0,
  parameter logic [63:0] ISA_BITS = 64'h0
) (
  input  csr_addr_t       addr_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] mip_i,
  input  logic [XLEN-1:0] mie_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mepc_i,
  input  logic [XLEN-1:0] sepc_i,
  input  logic [XLEN-1:0] mscratch_i,
  input  logic [XLEN-1:0] sscratch_i,
  input  logic [XLEN-1:0] mcause_i,
  input  logic [XLEN-1:0] scause_i,
  input  logic [XLEN-1:0] mbad_i,
  input  logic [XLEN-1:0] sbad_i,
  input  logic [XLEN-1:0] sptbr_i,
  input  logic [2:0]      ucnten_i,
  input  logic [2:0]      scnten_i,
  input  logic [63:0]     cnt_i [NUM_CNT],
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o
);
  localparam logic [XLEN-1:0] SMASK = XLEN'(ST_SVIEW_MASK);
  localparam bit NARROW = (XLEN == 32);

  always_comb begin
    rdata_o   = '0;
    illegal_o = 1'b0;
    case (addr_i)
      A_MSTATUS:  rdata_o = status_i;
      A_SSTATUS: begin
        rdata_o = status_i & SMASK;
        rdata_o[XLEN-1] = (status_i[ST_FS_LO +: 2] == 2'b11) ||
                          (status_i[ST_XS_LO +: 2] == 2'b11);
      end
      A_MIP:      rdata_o = mip_i;
      A_MIE:      rdata_o = mie_i;
      A_SIP:      rdata_o = mip_i & mideleg_i;
      A_SIE:      rdata_o = mie_i & mideleg_i;
      A_MIDELEG:  rdata_o = mideleg_i;
      A_MEDELEG:  rdata_o = medeleg_i;
      A_MTVEC:    rdata_o = mtvec_i;
      A_STVEC:    rdata_o = stvec_i;
      A_MEPC:     rdata_o = mepc_i;
      A_SEPC:     rdata_o = sepc_i;
      A_MSCRATCH: rdata_o = mscratch_i;
      A_SSCRATCH: rdata_o = sscratch_i;
      A_MCAUSE:   rdata_o = mcause_i;
      A_SCAUSE:   rdata_o = scause_i;
      A_MBADADDR: rdata_o = mbad_i;
      A_SBADADDR: rdata_o = sbad_i;
      A_SPTBR:    rdata_o = sptbr_i;
      A_UCNTEN:   rdata_o = XLEN'(ucnten_i);
      A_SCNTEN:   rdata_o = XLEN'(scnten_i);
      A_MISA:     rdata_o = XLEN'(ISA_BITS);
      A_VENDOR, A_ARCH, A_IMPL: rdata_o = '0;
      A_HART:     rdata_o = XLEN'(HART_ID);
      A_MCYCLE:   rdata_o = cnt_i[0][XLEN-1:0];
      A_MINSTRET: rdata_o = cnt_i[2][XLEN-1:0];
      A_MCYCLEH: begin
        rdata_o = XLEN'(cnt_i[0][63:32]);
        illegal_o = !NARROW;
      end
      A_MINSTRETH: begin
        rdata_o = XLEN'(cnt_i[2][63:32]);
        illegal_o = !NARROW;
      end
      default: begin
        illegal_o = 1'b1;
        for (int i = 0; i < NUM_CNT; i++) begin
          if ((addr_i == A_UCNT + csr_addr_t'(i) && ucnten_i[i]) ||
              (addr_i == A_SCNT + csr_addr_t'(i) && scnten_i[i])) begin
            rdata_o   = cnt_i[i][XLEN-1:0];
            illegal_o = 1'b0;
          end
          if (NARROW && ((addr_i == A_UCNTH + csr_addr_t'(i) && ucnten_i[i]) ||
                         (addr_i == A_SCNTH + csr_addr_t'(i) && scnten_i[i]))) begin
            rdata_o   = XLEN'(cnt_i[i][63:32]);
            illegal_o = 1'b0;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/priv_csr_file.sv
module priv_csr_file
  import csr_pkg::*;
#(
  parameter int          XLEN        = 64,
  parameter bit          HAS_EXT     = 1'b0,
  parameter int          HART_ID     = 0,
  parameter logic [63:0] ISA_BITS    = 64'h8000_0000_0014_112D,
  parameter logic [63:0] RESET_MTVEC = 64'h100,
  parameter logic [63:0] EXC_MASK    = 64'h0FFF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            we_i,
  input  logic [63:0]     mcycle_i,
  input  logic [63:0]     mtime_i,
  input  logic [63:0]     minstret_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o,
  output logic            flush_o
);
  localparam logic [XLEN-1:0] ALIGN = ~XLEN'(3);

  logic [XLEN-1:0] status_q, mip_q, mie_q, mideleg_q;
  logic [XLEN-1:0] medeleg_q, mtvec_q, stvec_q, mepc_q, sepc_q;
  logic [XLEN-1:0] mscratch_q, sscratch_q, mcause_q, scause_q;
  logic [XLEN-1:0] mbad_q, sbad_q, sptbr_q;
  logic [2:0]      ucnten_q, scnten_q;
  logic [63:0]     cnt [NUM_CNT];

  function automatic logic hit(input csr_addr_t a, input csr_addr_t t);
    return a == t;
  endfunction

  assign cnt[0] = mcycle_i;
  assign cnt[1] = mtime_i;
  assign cnt[2] = minstret_i;

  csr_status_unit #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_status (
    .clk_i, .rst_ni,
    .wr_m_i  (we_i && hit(addr_i, A_MSTATUS)),
    .wr_s_i  (we_i && hit(addr_i, A_SSTATUS)),
    .wdata_i,
    .status_o(status_q),
    .flush_o
  );

  csr_irq_unit #(.XLEN(XLEN)) u_irq (
    .clk_i, .rst_ni,
    .wr_mip_i  (we_i && hit(addr_i, A_MIP)),
    .wr_sip_i  (we_i && hit(addr_i, A_SIP)),
    .wr_mie_i  (we_i && hit(addr_i, A_MIE)),
    .wr_sie_i  (we_i && hit(addr_i, A_SIE)),
    .wr_deleg_i(we_i && hit(addr_i, A_MIDELEG)),
    .wdata_i,
    .mip_o     (mip_q),
    .mie_o     (mie_q),
    .mideleg_o (mideleg_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      medeleg_q  <= '0;
      mtvec_q    <= XLEN'(RESET_MTVEC);
      stvec_q    <= '0;
      mepc_q     <= '0;
      sepc_q     <= '0;
      mscratch_q <= '0;
      sscratch_q <= '0;
      mcause_q   <= '0;
      scause_q   <= '0;
      mbad_q     <= '0;
      sbad_q     <= '0;
      sptbr_q    <= '0;
      ucnten_q   <= '0;
      scnten_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MEDELEG:  medeleg_q  <= wdata_i & XLEN'(EXC_MASK);
        A_MTVEC:    mtvec_q    <= wdata_i & ALIGN;
        A_STVEC:    stvec_q    <= wdata_i & ALIGN;
        A_MEPC:     mepc_q     <= wdata_i;
        A_SEPC:     sepc_q     <= wdata_i;
        A_MSCRATCH: mscratch_q <= wdata_i;
        A_SSCRATCH: sscratch_q <= wdata_i;
        A_MCAUSE:   mcause_q   <= wdata_i;
        A_SCAUSE:   scause_q   <= wdata_i;
        A_MBADADDR: mbad_q     <= wdata_i;
        A_SBADADDR: sbad_q     <= wdata_i;
        A_SPTBR:    sptbr_q    <= wdata_i;
        A_UCNTEN:   ucnten_q   <= wdata_i[2:0];
        A_SCNTEN:   scnten_q   <= wdata_i[2:0];
        default: ;
      endcase
    end
  end

  csr_read_mux #(.XLEN(XLEN), .HART_ID(HART_ID), .ISA_BITS(ISA_BITS)) u_rd (
    .addr_i,
    .status_i  (status_q),
    .mip_i     (mip_q),
    .mie_i     (mie_q),
    .mideleg_i (mideleg_q),
    .medeleg_i (medeleg_q),
    .mtvec_i   (mtvec_q),
    .stvec_i   (stvec_q),
    .mepc_i    (mepc_q),
    .sepc_i    (sepc_q),
    .mscratch_i(mscratch_q),
    .sscratch_i(sscratch_q),
    .mcause_i  (mcause_q),
    .scause_i  (scause_q),
    .mbad_i    (mbad_q),
    .sbad_i    (sbad_q),
    .sptbr_i   (sptbr_q),
    .ucnten_i  (ucnten_q),
    .scnten_i  (scnten_q),
    .cnt_i     (cnt),
    .rdata_o,
    .illegal_o
  );
endmodule

// File: rtl/csr_file_chk.sv
module csr_file_chk
  import csr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_EXT = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [11:0]     addr_i,
  input logic [XLEN-1:0] rdata_o,
  input logic            illegal_o,
  input logic            flush_o,
  input logic [XLEN-1:0] status_q,
  input logic [XLEN-1:0] mip_q,
  input logic [XLEN-1:0] mie_q,
  input logic [XLEN-1:0] mideleg_q
);
  logic [VM_W-1:0] vm;
  assign vm = status_q[ST_VM_LO +: VM_W];

  assert_xs_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    HAS_EXT || (status_q[ST_XS_LO +: 2] == 2'b00));

  assert_vm_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vm == VM_BARE) || ((XLEN == 32) && (vm == VM_SV32)) ||
    ((XLEN == 64) && ((vm == VM_SV39) || (vm == VM_SV48))));

  assert_mpp_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[ST_MPP_LO +: 2] != PRV_RSV);

  assert_sd_summary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[XLEN-1] == ((status_q[ST_FS_LO +: 2] == 2'b11) ||
                         (status_q[ST_XS_LO +: 2] == 2'b11)));

  assert_flush_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (we_i && ((addr_i == A_MSTATUS) || (addr_i == A_SSTATUS))));

  assert_irq_masks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mip_q & ~XLEN'(IP_SW_MASK)) == '0) &&
    ((mie_q & ~XLEN'(IRQ_ALL_MASK)) == '0) &&
    ((mideleg_q & ~XLEN'(IRQ_DELEG_MASK)) == '0));

  assert_tvec_align_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && ((addr_i == A_MTVEC) || (addr_i == A_STVEC))) |-> (rdata_o[1:0] == 2'b00));

  assert_hold_idle_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(status_q) && $stable(mip_q) && $stable(mie_q) && $stable(mideleg_q)));
endmodule

bind priv_csr_file csr_file_chk #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .rdata_o, .illegal_o, .flush_o,
  .status_q, .mip_q, .mie_q, .mideleg_q
);

// File: tb/priv_csr_file_tb_top.sv
`timescale 1ns/1ps
module priv_csr_file_tb_top;
  localparam logic [63:0] CYC = 64'h1111_2222_3333_4444;
  localparam logic [63:0] TIM = 64'h5555_6666_7777_8888;
  localparam logic [63:0] INS = 64'h9999_AAAA_BBBB_CCCC;
  localparam logic [63:0] ISA64 = 64'h8000_0000_0014_112D;
  localparam logic [63:0] ISA32 = 64'h4014_112D;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        we = 1'b0;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic        il64, il32, fl64;
  logic [63:0] r64, r32;
  logic        i64, i32, flq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  priv_csr_file #(.XLEN(64), .HAS_EXT(1'b1), .HART_ID(5), .ISA_BITS(ISA64)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .mcycle_i(CYC), .mtime_i(TIM), .minstret_i(INS),
    .rdata_o(rd64), .illegal_o(il64), .flush_o(fl64));

  logic fl32;
  priv_csr_file #(.XLEN(32), .HAS_EXT(1'b0), .HART_ID(9), .ISA_BITS(ISA32)) dut_x_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata[31:0]), .we_i(we),
    .mcycle_i(CYC), .mtime_i(TIM), .minstret_i(INS),
    .rdata_o(rd32), .illegal_o(il32), .flush_o(fl32));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    #2 flq = fl64;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    addr = a; we = 1'b0;
    #2;
    r64 = rd64; i64 = il64; r32 = {32'h0, rd32}; i32 = il32;
  endtask

  task automatic t_reset;
    rd(12'h300); chk("R1 mstatus64", r64, 0); chk("R1 mstatus32", r32, 0);
    rd(12'h305); chk("R1 mtvec", r64, 64'h100);
    rd(12'h303); chk("R1 mideleg", r64, 0);
    rd(12'h344); chk("R1 mip", r64, 0);
    chk("R1 flush idle", {63'h0, fl64}, 0);
  endtask

  task automatic t_status_mask;
    wr(12'h300, ONES);
    chk("R6 flush on mpp change", {63'h0, flq}, 1);
    rd(12'h300);
    chk("R2 R5 mstatus64 ones", r64, 64'h8000_0000_0007_F9AA);
    chk("R2 R5 mstatus32 ones no xs", r32, 64'h8006_79AA);
  endtask

  task automatic t_legalize;
    wr(12'h300, 64'h0900_3000);
    rd(12'h300);
    chk("R3 R4 vm9 ok mpp2 kept 64", r64, 64'h0900_3800);
    chk("R3 vm9 rejected 32", r32, 64'h3800);
    wr(12'h300, 64'h0800_0800);
    rd(12'h300);
    chk("R3 vm8 rejected 64", r64, 64'h0900_0800);
    chk("R3 R4 vm8 ok mpp1 32", r32, 64'h0800_0800);
  endtask

  task automatic t_flush;
    wr(12'h300, 64'h0900_0800); chk("R6 no change", {63'h0, flq}, 0);
    wr(12'h300, 64'h0900_0808); chk("R6 mie only", {63'h0, flq}, 0);
    wr(12'h300, 64'h0902_0808); chk("R6 mprv change", {63'h0, flq}, 1);
  endtask

  task automatic t_sstatus;
    rd(12'h100); chk("R8 sstatus view", r64, 0);
    wr(12'h100, ONES); chk("R6 pum via sstatus", {63'h0, flq}, 1);
    rd(12'h300); chk("R8 mstatus after sstatus", r64, 64'h8000_0000_0907_E92A);
    rd(12'h100); chk("R8 sstatus sd", r64, 64'h8000_0000_0005_E122);
  endtask

  task automatic t_irq;
    wr(12'h344, ONES); rd(12'h344); chk("R7 mip mask", r64, 64'h22);
    wr(12'h304, ONES); rd(12'h304); chk("R7 mie mask", r64, 64'h12AA);
    wr(12'h303, ONES); rd(12'h303); chk("R7 mideleg mask", r64, 64'h1222);
  endtask

  task automatic t_sview;
    wr(12'h303, 64'h2);
    wr(12'h344, 64'h0);
    wr(12'h144, ONES);
    rd(12'h344); chk("R9 sip write", r64, 64'h2);
    rd(12'h144); chk("R9 sip read", r64, 64'h2);
    wr(12'h304, 64'h0);
    wr(12'h104, ONES);
    rd(12'h304); chk("R9 sie write", r64, 64'h2);
    wr(12'h304, 64'h12AA);
    wr(12'h104, 64'h0);
    rd(12'h304); chk("R9 sie clears delegated only", r64, 64'h12A8);
    rd(12'h104); chk("R9 sie read", r64, 64'h0);
  endtask

  task automatic t_tvec_cnten;
    wr(12'h305, 64'h1237); rd(12'h305); chk("R10 mtvec align", r64, 64'h1234);
    wr(12'h105, 64'hFFF);  rd(12'h105); chk("R10 stvec align", r64, 64'hFFC);
    wr(12'h320, ONES);     rd(12'h320); chk("R10 ucnten bits", r64, 64'h7);
    wr(12'h321, 64'h5);    rd(12'h321); chk("R10 scnten", r64, 64'h5);
  endtask

  task automatic t_counters;
    rd(12'hC00); chk("R11 cycle", r64, CYC); chk("R11 cycle legal", {63'h0, i64}, 0);
    rd(12'hC02); chk("R11 instret", r64, INS);
    wr(12'h320, 64'h2);
    rd(12'hC00); chk("R11 cycle gated", {63'h0, i64}, 1);
    rd(12'hC01); chk("R11 time enabled", r64, TIM);
    rd(12'hD00); chk("R11 scycle", r64, CYC);
    rd(12'hD01); chk("R11 stime gated", {63'h0, i64}, 1);
    rd(12'h7C0); chk("R11 unknown addr", {63'h0, i64}, 1);
    rd(12'hC80); chk("R12 high half illegal 64", {63'h0, i64}, 1);
    chk("R12 cycleh gated 32", {63'h0, i32}, 1);
    rd(12'hC81); chk("R12 timeh 32", r32, {32'h0, TIM[63:32]});
    chk("R12 timeh legal 32", {63'h0, i32}, 0);
    rd(12'hB80); chk("R12 mcycleh 32", r32, {32'h0, CYC[63:32]});
    chk("R12 mcycleh illegal 64", {63'h0, i64}, 1);
    rd(12'hB00); chk("R12 mcycle 64", r64, CYC);
  endtask

  task automatic t_ids;
    wr(12'hF11, ONES);
    rd(12'hF11); chk("R13 vendor zero", r64, 0);
    rd(12'hF12); chk("R13 arch zero", r64, 0);
    rd(12'hF14); chk("R13 hart64", r64, 5); chk("R13 hart32", r32, 9);
    rd(12'h301); chk("R13 isa", r64, ISA64);
  endtask

  task automatic t_isolation;
    wr(12'h340, 64'hAAAA);
    wr(12'h140, 64'h5555);
    rd(12'h340); chk("R14 mscratch kept", r64, 64'hAAAA);
    rd(12'h140); chk("R14 sscratch", r64, 64'h5555);
    wr(12'h7C0, 64'h1234);
    rd(12'h340); chk("R14 undecoded write", r64, 64'hAAAA);
    rd(12'h305); chk("R14 mtvec untouched", r64, 64'h1234);
    wr(12'h341, 64'hBEEF);
    rd(12'h141); chk("R14 sepc untouched", r64, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_mask();
    t_legalize();
    t_flush();
    t_sstatus();
    t_irq();
    t_sview();
    t_tvec_cnten();
    t_counters();
    t_ids();
    t_isolation();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule